// File: doc/BRIEF.md
# Bus Yield Arbiter

This block lets an outside master take the memory buses away from a processor core. The outside master raises an asynchronous request. The block synchronises it, then waits until the core is not in the middle of an external memory cycle. It then raises the grant, turns off the core's address, data and strobe drivers, and tells the core to halt. When the request goes away, the block drops the grant, turns the drivers back on and releases the halt. The core then carries on from the instruction where it stopped.

An optional go-mode lets the core keep running while it does not own the bus. In that mode the halt is raised only when the current instruction actually needs an external access. The core can perform two external accesses for a single instruction. If the core leaves one idle cycle between them, a pending request is granted in that gap, and the second access waits until the bus comes back.

The block is reset only by its own power-on reset `rst_n`. Core reset and boot loading do not touch it, so the request is honoured at all times. Every port is a plain control or status pin. No data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `bus_yield_arbiter`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `bus_grant` is 0, `bus_oe` is 1 and `core_halt` is 0. `rst_n` acts at once, without waiting for a clock edge.
- R2: `bus_req_in` passes through a two-flop synchroniser. If the bus is idle, `bus_grant` rises on the third rising edge after `bus_req_in` goes high.
- R3: `bus_grant` does not rise on an edge where `ext_busy` is sampled high. It rises on the first edge where the synchronised request is high and `ext_busy` is sampled low. This holds however long the access lasts.
- R4: `bus_oe` is always the inverse of `bus_grant`. It falls on the same edge where the grant rises, and it rises on the same edge where the grant falls.
- R5: When `go_mode` is 0, `core_halt` equals `bus_grant`.
- R6: When `go_mode` is 1, `core_halt` is high only while `bus_grant` is high and `ext_need` is high. It follows `ext_need` within the same cycle.
- R7: After `bus_req_in` goes low, `bus_grant` falls on the third rising edge. At that edge `bus_oe` returns to 1 and `core_halt` returns to 0.
- R8: One idle cycle of `ext_busy` between two accesses is enough for a pending request to be granted.
- R9: Once granted, `bus_grant` stays high for as long as the synchronised request stays high, whatever `ext_need` and `go_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_req_in | input | 1 | Asynchronous bus request from the outside master, active high |
| ext_busy | input | 1 | The core has an external memory cycle in progress this cycle |
| ext_need | input | 1 | The core's current instruction needs an external access |
| go_mode | input | 1 | 1: keep executing until an external access is needed |
| bus_grant | output | 1 | Bus granted to the outside master |
| bus_oe | output | 1 | Enable for the core's address, data and strobe drivers |
| core_halt | output | 1 | Stall the core |

## Verification
The assertions assume that the core obeys the halt. This means `ext_busy` is never high while `bus_grant` is high. It also means the core inserts at least one idle cycle before a deferred second access. The stimulus keeps `ext_busy` low in every cycle from the edge where the grant rises until the grant falls. Inputs change only on the falling clock edge, so the synchroniser sees a clean request with no metastability.

// File: rtl/yield_pkg.sv
package yield_pkg;
  typedef enum logic [0:0] {
    OWNED   = 1'b0,
    YIELDED = 1'b1
  } own_state_t;

  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/yield_grant_fsm.sv
module yield_grant_fsm
  import yield_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync,
  input  logic ext_busy,
  output logic grant,
  output logic oe
);
  own_state_t state_q, state_d;
  logic       oe_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      OWNED:   if (req_sync && !ext_busy) state_d = YIELDED;
      YIELDED: if (!req_sync)             state_d = OWNED;
      default:                            state_d = OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OWNED;
      oe_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      oe_q    <= (state_d == OWNED);
    end
  end

  assign grant = (state_q == YIELDED);
  assign oe    = oe_q;

  AST_BUSY_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && ext_busy) |=> !grant); // R3
  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && req_sync && !ext_busy) |=> grant); // R2
  AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_sync) |=> !grant); // R7
  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_sync) |=> grant); // R9
endmodule

// File: rtl/yield_halt_ctl.sv
module yield_halt_ctl (
  input  logic grant,
  input  logic go_mode,
  input  logic ext_need,
  output logic halt
);
  always_comb begin
    if (!grant)       halt = 1'b0;
    else if (go_mode) halt = ext_need;
    else              halt = 1'b1;
  end

  always_comb begin
    AST_GO_DEFERS_HALT: assert (!(go_mode && !ext_need && halt)); // R6
  end
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
  import yield_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_in,
  input  logic ext_busy,
  input  logic ext_need,
  input  logic go_mode,
  output logic bus_grant,
  output logic bus_oe,
  output logic core_halt
);
  logic req_sync;

  yield_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (bus_req_in),
    .dout (req_sync)
  );

  yield_grant_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_sync(req_sync),
    .ext_busy(ext_busy),
    .grant   (bus_grant),
    .oe      (bus_oe)
  );

  yield_halt_ctl u_halt (
    .grant   (bus_grant),
    .go_mode (go_mode),
    .ext_need(ext_need),
    .halt    (core_halt)
  );

  AST_OE_OPPOSES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe != bus_grant); // R4
  AST_HALT_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !go_mode |-> (core_halt == bus_grant)); // R5
  AST_NO_HALT_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> !core_halt); // R6
endmodule

// File: tb/sim_bus_yield_arbiter.sv
module sim_bus_yield_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_in = 1'b0, ext_busy = 1'b0, ext_need = 1'b0, go_mode = 1'b0;
  logic bus_grant, bus_oe, core_halt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_yield_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .bus_req_in(bus_req_in), .ext_busy(ext_busy),
    .ext_need(ext_need), .go_mode(go_mode), .bus_grant(bus_grant),
    .bus_oe(bus_oe), .core_halt(core_halt)
  );

  // {req, busy, need, go, exp_grant, exp_oe, exp_halt}
  localparam logic [6:0] VEC [32] = '{
    7'b0000_010, 7'b1000_010, 7'b1000_010, 7'b1000_101, // R2 latency
    7'b1001_100, 7'b1011_101,                           // R6 go-mode
    7'b0000_101, 7'b0000_101, 7'b0000_010,              // R7 release
    7'b1100_010, 7'b1100_010, 7'b1100_010, 7'b1100_010, // R3 busy
    7'b1000_101, 7'b0000_101, 7'b0000_101, 7'b0000_010, // R3 then R7
    7'b1100_010, 7'b1100_010, 7'b1000_101, 7'b1000_101, // R8 gap
    7'b0000_101, 7'b0000_101, 7'b0000_010,
    7'b1001_010, 7'b1001_010, 7'b1001_100, 7'b1011_101, // R6
    7'b1001_100, 7'b0001_100, 7'b0001_100, 7'b0001_010
  };
  localparam int VREQ [32] = '{1,2,2,2, 6,6, 7,7,7, 3,3,3,3, 3,7,7,7,
                               8,8,8,8, 7,7,7, 6,6,6,6, 6,7,7,7};

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic b, input logic n, input logic g);
    bus_req_in = r; ext_busy = b; ext_need = n; go_mode = g;
    @(negedge clk);
  endtask

  task automatic expect3(input logic g, input logic o, input logic h, input string tag);
    chk(bus_grant, g, {tag, " grant"});
    chk(bus_oe, o, "R4 oe");
    chk(core_halt, h, {tag, " halt"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect3(1'b0, 1'b1, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect3(1'b0, 1'b1, 1'b0, "R1");

    for (int i = 0; i < 32; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      expect3(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R%0d", VREQ[i]));
    end

    // R3: an eight-cycle access holds the grant off
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0);
      chk(bus_grant, 1'b0, "R3 long access");
    end
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk(bus_grant, 1'b1, "R3 after access");

    // R9: grant held while need and go-mode toggle
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, k[0], k[1]);
      chk(bus_grant, 1'b1, "R9 hold");
    end

    // R1: asynchronous reset while granted
    #1 rst_n = 1'b0;
    #0.5;
    expect3(1'b0, 1'b1, 1'b0, "R1 async");
    bus_req_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect3(1'b0, 1'b1, 1'b0, "R1 after");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule